// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a load/store unit and a word-wide memory port. It serves 32-bit byte-addressed loads and stores of byte, halfword or word size out of a direct-mapped array of lines. Each address maps to exactly one line. Stores that hit only mark the line dirty. Dirty data reaches memory in three cases: the line is evicted by a miss, the line is flushed by an explicit maintenance command, or the store took an uncached path.

The CPU side is a ready/valid request with one request in flight. Every request ends in a one-cycle response pulse. The memory side is a request/acknowledge port that moves one word per acknowledge. It holds the request, address and data steady until that word is acknowledged. Line fills and write-backs are bursts of consecutive words, lowest word first.

Two bypass paths skip the array entirely: a per-request I/O flag, and (when enabled by parameter) address bit 31. Two maintenance commands act on the line selected by an address. One discards the line. The other writes it back if dirty and then discards it.

Top module: `wb_line_cache`

## Requirements
- R1: After reset the block sweeps every line invalid, one line per cycle, and holds `req_ready` low until the sweep is complete. The first cached load then misses and fetches its line.
- R2: Placement is direct-mapped. The line index is taken from the address bits just above the line offset. A cached access that hits makes no memory traffic. Lines at different indexes stay resident side by side.
- R3: Loads are little-endian. `req_size` is 0 for byte, 1 for halfword and 2 for word. A byte or halfword is taken from the lane given by the low address bits and placed in the low bits of `rsp_data`. It is sign-extended when `req_signed` is 1 and zero-extended otherwise.
- R4: A cached store that hits writes only its byte lanes, taking the data from the low bits of `req_wdata`, and marks the line dirty. It makes no memory traffic.
- R5: A miss on a valid dirty line first writes the victim back as a burst of all its words, lowest word first, at the victim's address. Only after that does it fetch the new line.
- R6: The discard command (`req_op`=2) clears the valid bit of the line holding the given address. It writes nothing back, even if the line is dirty.
- R7: The flush command (`req_op`=3) writes a dirty matching line back and then clears its valid bit. A clean matching line is invalidated with no memory traffic.
- R8: A load or store with `req_io`=1 makes exactly one single-word memory access. For stores this access uses the store's byte enables. It neither allocates a line nor changes a resident line.
- R9: With `BYPASS_BIT31`=1, a load or store whose address has bit 31 set is handled exactly like an I/O access.
- R10: `req_ready` is high only while the block is idle. `rsp_valid` is a one-cycle pulse, and `rsp_data` is zero for non-load operations. A memory request keeps its address and direction stable until acknowledged. `req_op` encodes 0 load, 1 store, 2 discard, 3 flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 discard line, 3 flush line |
| req_io | input | 1 | Bypass the cache for this access |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_signed | input | 1 | Sign-extend narrow loads |
| req_wdata | input | 32 | Store data in the low bits |
| rsp_valid | output | 1 | Request complete (one cycle) |
| rsp_data | output | 32 | Load result, zero otherwise |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Memory write when high |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Current word done |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
The properties assume a memory that only raises `mem_ack` while `mem_req` is high. They also assume that each narrow access is naturally aligned, so a halfword never crosses a word and a word never crosses a line. The stimulus meets both assumptions. The bench memory acknowledges on alternate cycles, and only while a request is present. Every address it drives is aligned to its size. It also waits for each response before issuing the next request.

// File: rtl/wb_line_cache.sv
module wb_line_cache #(
  parameter int LINE_BYTES   = 16,
  parameter int NUM_LINES    = 16,
  parameter bit BYPASS_BIT31 = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_op,
  input  logic        req_io,
  input  logic [31:0] req_addr,
  input  logic [1:0]  req_size,
  input  logic        req_signed,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int WPL = LINE_BYTES / 4;
  localparam int OFF = $clog2(LINE_BYTES);
  localparam int IW  = $clog2(NUM_LINES);
  localparam int TW  = 32 - OFF - IW;
  localparam int DW  = IW + OFF - 2;
  localparam int BW  = (WPL > 1) ? $clog2(WPL) : 1;

  typedef enum logic [2:0] {S_CLR, S_IDLE, S_LOOK, S_WB, S_FILL, S_UNC, S_RESP} st_t;
  st_t st;

  logic [1:0]  r_op, r_size;
  logic        r_io, r_sgn;
  logic [31:0] r_addr, r_wdata;
  logic [TW-1:0] tags_q [NUM_LINES];
  logic [31:0]   data_q [NUM_LINES*WPL];
  logic [NUM_LINES-1:0] valid_q, dirty_q;
  logic [IW-1:0] clr_idx;
  logic [BW-1:0] beat;

  wire [IW-1:0] idx  = r_addr[OFF+IW-1:OFF];
  wire [TW-1:0] rtag = r_addr[31:OFF+IW];
  wire [DW-1:0] didx = r_addr[OFF+IW-1:2];
  wire [DW-1:0] bdi  = (DW'(idx) << (OFF-2)) + DW'(beat);
  wire hit      = valid_q[idx] && (tags_q[idx] == rtag);
  wire uncached = r_io || (BYPASS_BIT31 && r_addr[31]);
  wire last     = (beat == BW'(WPL-1));
  wire sweeping = (st == S_CLR);

  wire [31:0] lanes = (r_size == 2'd0) ? {4{r_wdata[7:0]}} :
                      (r_size == 2'd1) ? {2{r_wdata[15:0]}} : r_wdata;
  wire [3:0]  be    = (r_size == 2'd0) ? (4'b0001 << r_addr[1:0]) :
                      (r_size == 2'd1) ? (4'b0011 << {r_addr[1], 1'b0}) : 4'hF;

  function automatic logic [31:0] pick(input logic [31:0] w, input logic [1:0] a,
                                       input logic [1:0] sz, input logic sg);
    logic [31:0] sh;
    sh = w >> {a, 3'b000};
    if (sz == 2'd0)      return {{24{sg & sh[7]}}, sh[7:0]};
    else if (sz == 2'd1) return {{16{sg & sh[15]}}, sh[15:0]};
    else                 return w;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] en);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = en[i] ? nw[8*i +: 8] : old[8*i +: 8];
    return m;
  endfunction

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RESP);
  assign mem_req   = (st == S_WB) || (st == S_FILL) || (st == S_UNC);
  assign mem_we    = (st == S_WB) || (st == S_UNC && r_op == 2'd1);
  assign mem_be    = (st == S_UNC) ? be : 4'hF;
  assign mem_wdata = (st == S_WB) ? data_q[bdi] : lanes;
  assign mem_addr  = (st == S_WB)   ? ((32'(tags_q[idx]) << (OFF+IW)) | (32'(idx) << OFF) | (32'(beat) << 2)) :
                     (st == S_FILL) ? ({r_addr[31:OFF], {OFF{1'b0}}} | (32'(beat) << 2)) :
                                      {r_addr[31:2], 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_CLR; clr_idx <= '0; beat <= '0; rsp_data <= '0;
      r_op <= '0; r_size <= '0; r_io <= 1'b0; r_sgn <= 1'b0; r_addr <= '0; r_wdata <= '0;
    end else begin
      case (st)
        S_CLR: begin
          valid_q[clr_idx] <= 1'b0;
          dirty_q[clr_idx] <= 1'b0;
          clr_idx <= clr_idx + 1'b1;
          if (clr_idx == IW'(NUM_LINES-1)) st <= S_IDLE;
        end
        S_IDLE: if (req_valid) begin
          r_op <= req_op; r_io <= req_io; r_addr <= req_addr;
          r_size <= req_size; r_sgn <= req_signed; r_wdata <= req_wdata;
          rsp_data <= '0;
          st <= S_LOOK;
        end
        S_LOOK: begin
          beat <= '0;
          if (r_op == 2'd2) begin
            if (hit) valid_q[idx] <= 1'b0;
            st <= S_RESP;
          end else if (r_op == 2'd3) begin
            if (hit && dirty_q[idx]) st <= S_WB;
            else begin
              if (hit) valid_q[idx] <= 1'b0;
              st <= S_RESP;
            end
          end else if (uncached) st <= S_UNC;
          else if (hit) begin
            if (r_op == 2'd0) rsp_data <= pick(data_q[didx], r_addr[1:0], r_size, r_sgn);
            else begin
              data_q[didx] <= merge(data_q[didx], lanes, be);
              dirty_q[idx] <= 1'b1;
            end
            st <= S_RESP;
          end else st <= (valid_q[idx] && dirty_q[idx]) ? S_WB : S_FILL;
        end
        S_WB: if (mem_ack) begin
          beat <= beat + 1'b1;
          if (last) begin
            beat <= '0;
            dirty_q[idx] <= 1'b0;
            if (r_op == 2'd3) begin valid_q[idx] <= 1'b0; st <= S_RESP; end
            else st <= S_FILL;
          end
        end
        S_FILL: if (mem_ack) begin
          data_q[bdi] <= mem_rdata;
          beat <= beat + 1'b1;
          if (last) begin
            valid_q[idx] <= 1'b1; dirty_q[idx] <= 1'b0; tags_q[idx] <= rtag;
            st <= S_LOOK;
          end
        end
        S_UNC: if (mem_ack) begin
          if (r_op == 2'd0) rsp_data <= pick(mem_rdata, r_addr[1:0], r_size, r_sgn);
          st <= S_RESP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wb_line_cache_chk.sv
module wb_line_cache_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic        sweeping
);
  assert_no_ready_in_sweep_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sweeping |-> !req_ready);
  assert_write_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);
  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_idle_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req && !rsp_valid));
endmodule

bind wb_line_cache wb_line_cache_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .sweeping(sweeping)
);

// File: tb/wb_line_cache_tb_top.sv
module wb_line_cache_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_io = 1'b0, req_signed = 1'b0;
  logic [1:0] req_op = '0, req_size = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid, mem_req, mem_we;
  logic [31:0] rsp_data, mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic mem_ack = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wb_line_cache dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_io(req_io), .req_addr(req_addr), .req_size(req_size),
    .req_signed(req_signed), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  logic [31:0] mem_m [1024];
  int rd_beats = 0, wr_beats = 0, cyc = 0;
  int first_rd_cyc = 0, last_wr_cyc = 0;
  logic [31:0] first_wr_addr = '0, last_wr_addr = '0;
  bit wr_seen = 0;
  assign mem_rdata = mem_m[mem_addr[11:2]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_ack <= mem_req && !mem_ack;
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        for (int i = 0; i < 4; i++)
          if (mem_be[i]) mem_m[mem_addr[11:2]][8*i +: 8] <= mem_wdata[8*i +: 8];
        wr_beats <= wr_beats + 1;
        last_wr_cyc <= cyc;
        last_wr_addr <= mem_addr;
        if (!wr_seen) begin first_wr_addr <= mem_addr; wr_seen <= 1; end
      end else begin
        rd_beats <= rd_beats + 1;
        if (first_rd_cyc == 0) first_rd_cyc <= cyc;
      end
    end
  end

  int n_chk = 0, n_err = 0, issued = 0, done = 0, rd0 = 0, wr0 = 0;
  logic [31:0] exp_q[$];
  string rq_q[$];

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  always @(negedge clk) if (rsp_valid) begin
    if (exp_q.size() == 0) check("R10", 32'd1, 32'd0);
    else check(rq_q.pop_front(), rsp_data, exp_q.pop_front());
    done++;
  end

  task automatic mark();
    rd0 = rd_beats; wr0 = wr_beats; first_rd_cyc = 0; wr_seen = 0;
  endtask

  task automatic traffic(string rq, int rd, int wr);
    check(rq, 32'(rd_beats - rd0), 32'(rd));
    check(rq, 32'(wr_beats - wr0), 32'(wr));
  endtask

  task automatic do_req(logic [1:0] op, logic io, logic [31:0] a, logic [1:0] sz,
                        logic sg, logic [31:0] wd, logic [31:0] exp, string rq);
    while (!req_ready) @(negedge clk);
    exp_q.push_back(exp); rq_q.push_back(rq); issued++;
    req_valid = 1'b1; req_op = op; req_io = io; req_addr = a;
    req_size = sz; req_signed = sg; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10", {31'd0, req_ready}, 32'd0);
    while (done < issued) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog R10 actual=%h expected=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem_m[i] = 32'h8C7B0000 | 32'(i);
    repeat (3) @(negedge clk);
    check("R10", {31'd0, req_ready}, 32'd0);
    check("R10", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {31'd0, req_ready}, 32'd0);
    check("R1", {31'd0, mem_req}, 32'd0);
    // R1 / R2: first load fills, neighbour word hits
    mark(); do_req(0, 0, 32'h100, 2, 0, 0, 32'h8C7B0040, "R1"); traffic("R1", 4, 0);
    mark(); do_req(0, 0, 32'h104, 2, 0, 0, 32'h8C7B0041, "R2"); traffic("R2", 0, 0);
    // R3: lanes and extension
    do_req(0, 0, 32'h106, 0, 1, 0, 32'h0000007B, "R3");
    do_req(0, 0, 32'h107, 0, 1, 0, 32'hFFFFFF8C, "R3");
    do_req(0, 0, 32'h107, 0, 0, 0, 32'h0000008C, "R3");
    do_req(0, 0, 32'h106, 1, 1, 0, 32'hFFFF8C7B, "R3");
    do_req(0, 0, 32'h106, 1, 0, 0, 32'h00008C7B, "R3");
    do_req(0, 0, 32'h104, 0, 1, 0, 32'h00000041, "R3");
    // R4: narrow store hits
    mark();
    do_req(1, 0, 32'h109, 0, 0, 32'h000000EE, 32'h0, "R4");
    do_req(0, 0, 32'h108, 2, 0, 0, 32'h8C7BEE42, "R4");
    do_req(1, 0, 32'h10A, 1, 0, 32'h00001234, 32'h0, "R4");
    do_req(0, 0, 32'h108, 2, 0, 0, 32'h1234EE42, "R4");
    traffic("R4", 0, 0);
    check("R4", mem_m[66], 32'h8C7B0042);
    // R5: dirty victim written back before fill
    mark(); do_req(0, 0, 32'h500, 2, 0, 0, 32'h8C7B0140, "R5"); traffic("R5", 4, 4);
    check("R5", first_wr_addr, 32'h100);
    check("R5", last_wr_addr, 32'h10C);
    check("R5", mem_m[66], 32'h1234EE42);
    check("R5", {31'd0, last_wr_cyc < first_rd_cyc}, 32'd1);
    // R6: discard drops dirty data
    do_req(1, 0, 32'h500, 2, 0, 32'hDEADBEEF, 32'h0, "R6");
    mark(); do_req(2, 0, 32'h500, 2, 0, 0, 32'h0, "R6"); traffic("R6", 0, 0);
    mark(); do_req(0, 0, 32'h500, 2, 0, 0, 32'h8C7B0140, "R6"); traffic("R6", 4, 0);
    // R7: flush dirty, then flush clean
    do_req(1, 0, 32'h504, 2, 0, 32'hCAFEF00D, 32'h0, "R7");
    mark(); do_req(3, 0, 32'h504, 2, 0, 0, 32'h0, "R7"); traffic("R7", 0, 4);
    check("R7", mem_m[321], 32'hCAFEF00D);
    mark(); do_req(0, 0, 32'h504, 2, 0, 0, 32'hCAFEF00D, "R7"); traffic("R7", 4, 0);
    mark(); do_req(3, 0, 32'h504, 2, 0, 0, 32'h0, "R7"); traffic("R7", 0, 0);
    mark(); do_req(0, 0, 32'h504, 2, 0, 0, 32'hCAFEF00D, "R7"); traffic("R7", 4, 0);
    // R8: I/O bypass
    mem_m[321] = 32'h11112222;
    mark(); do_req(0, 1, 32'h504, 2, 0, 0, 32'h11112222, "R8"); traffic("R8", 1, 0);
    mark(); do_req(0, 0, 32'h504, 2, 0, 0, 32'hCAFEF00D, "R8"); traffic("R8", 0, 0);
    mark(); do_req(1, 1, 32'h508, 2, 0, 32'h33334444, 32'h0, "R8"); traffic("R8", 0, 1);
    check("R8", mem_m[322], 32'h33334444);
    mark(); do_req(0, 0, 32'h508, 2, 0, 0, 32'h8C7B0142, "R8"); traffic("R8", 0, 0);
    do_req(1, 1, 32'h50D, 0, 0, 32'h000000AB, 32'h0, "R8");
    check("R8", mem_m[323], 32'h8C7BAB43);
    // R9: address bit 31 bypass
    mark(); do_req(0, 0, 32'h80000504, 2, 0, 0, 32'h11112222, "R9"); traffic("R9", 1, 0);
    mark(); do_req(1, 0, 32'h80000500, 2, 0, 32'h55556666, 32'h0, "R9"); traffic("R9", 0, 1);
    check("R9", mem_m[320], 32'h55556666);
    mark(); do_req(0, 0, 32'h500, 2, 0, 0, 32'h8C7B0140, "R9"); traffic("R9", 0, 0);
    // R2: other index coexists
    mark(); do_req(0, 0, 32'h110, 2, 0, 0, 32'h8C7B0044, "R2"); traffic("R2", 4, 0);
    mark(); do_req(0, 0, 32'h504, 2, 0, 0, 32'hCAFEF00D, "R2"); traffic("R2", 0, 0);
    @(negedge clk);
    check("R10", {31'd0, rsp_valid}, 32'd0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule